// File: doc/BRIEF.md
# Byte-wide parallel memory configuration master

This block leads a serial configuration chain. It reads a stream of bytes from a parallel memory, starting at address zero, and sends each byte out on one serial data line. It also generates the configuration clock that it and every downstream device use. A system clock is divided by the parameter `DIV` to form one configuration clock period. One memory byte covers exactly eight periods, so the address advances at one eighth of the bit rate.

The serial data line changes only on the falling edge of the configuration clock, so receivers sample on the rising edge. The next byte is read from the memory bus one system clock before the last bit period of the current byte ends. Bytes therefore follow each other with no idle period between them.

The block stops fetching in either of two cases:
- the byte at address `MAX_ADDR` has been fully sent;
- the chain reports completion on `chain_done`.

When it stops, the clock and the data line rest high.

Top module: `cfgbyte_master`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the address to zero, stops any transfer and drives `cfg_clk` and `cfg_dout` high.
- R2: When idle, a `start` sampled high sets `mem_addr` to 0 at that edge. One wait cycle follows. At the second edge `cfg_clk` falls, `cfg_dout` shows bit 0 of the byte at address 0, and `mem_addr` becomes 1. `start` has no effect while a transfer is running.
- R3: While streaming, rising edges of `cfg_clk` are exactly `DIV` system cycles apart. Each period is low for `DIV/2` cycles (rounded down) and then high, which gives a 50 % duty cycle for even `DIV`.
- R4: While streaming, `cfg_dout` changes only in the same cycle that `cfg_clk` falls.
- R5: Each byte is sent bit 0 first through bit 7, one bit per `cfg_clk` period. The bytes of consecutive addresses follow back to back, in address order.
- R6: `mem_addr` only ever changes to zero or to its previous value plus one. While streaming, it advances once every `8*DIV` system cycles. The first step after the initial 0→1 comes `8*DIV-1` cycles after that step. The byte is taken from `mem_data` at the edge where the address steps.
- R7: After the byte at address `MAX_ADDR` has been sent, the block becomes idle. At that point exactly `8*(MAX_ADDR+1)` rising clock edges have occurred, `cfg_clk` and `cfg_dout` are high, and `mem_addr` holds `MAX_ADDR`.
- R8: A `chain_done` sampled high during a transfer makes the block idle at that edge. `cfg_clk` and `cfg_dout` go high, no further clock pulses follow, and `mem_addr` stays frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a configuration transfer when idle |
| chain_done | input | 1 | Completion report from the chain; halts the transfer |
| mem_addr | output | AW | Address of the memory byte being fetched |
| mem_data | input | 8 | Byte returned by the memory |
| cfg_clk | output | 1 | Configuration clock to self and downstream devices |
| cfg_dout | output | 1 | Serial configuration data, changes on falling edges |

## Verification
The bench targets these corner cases:
- The seam between two bytes. A late prefetch would repeat or drop a byte or leave a gap in the clock.
- The first bit after start. An off-by-one wait would shift the whole stream by one position.
- The final byte at `MAX_ADDR`. A wrong stop test would emit an extra byte or cut off the last one.
- A `chain_done` or reset in mid-stream. The bench checks that the clock stops at once with both lines high and that a later start restarts from address zero.
- Memory patterns of all ones, all zeros and a walking one. A reversed bit order or a data change on the rising edge would show up as byte mismatches or as R4 violations.

// File: rtl/cfgbyte_master.sv
module cfgbyte_master #(
  parameter int DIV      = 4,
  parameter int AW       = 8,
  parameter int MAX_ADDR = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          chain_done,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_data,
  output logic          cfg_clk,
  output logic          cfg_dout
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int LO = DIV / 2;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    shreg, nbuf;
  logic          have_last, final_q;
  logic          run_w, wrap, latch;
  logic [CW-1:0] cnt_inc;

  assign run_w   = (st == S_RUN);
  assign wrap    = (cnt == CW'(DIV - 1));
  assign latch   = (bitn == 3'd7) && (cnt == CW'(DIV - 2)) && !have_last;
  assign cnt_inc = cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      mem_addr  <= '0;
      cnt       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      nbuf      <= '0;
      have_last <= 1'b0;
      final_q   <= 1'b0;
      cfg_clk   <= 1'b1;
      cfg_dout  <= 1'b1;
    end else if (st != S_IDLE && chain_done) begin
      st       <= S_IDLE;
      cfg_clk  <= 1'b1;
      cfg_dout <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          mem_addr <= '0;
          st       <= S_WAIT;
        end
        S_WAIT: begin
          st        <= S_RUN;
          shreg     <= mem_data;
          cfg_dout  <= mem_data[0];
          cfg_clk   <= 1'b0;
          cnt       <= '0;
          bitn      <= '0;
          mem_addr  <= mem_addr + AW'(1);
          have_last <= 1'b0;
          final_q   <= 1'b0;
        end
        S_RUN: begin
          cnt <= wrap ? '0 : cnt_inc;
          if (!wrap) cfg_clk <= (cnt_inc >= CW'(LO));
          if (latch) begin
            nbuf <= mem_data;
            if (mem_addr == AW'(MAX_ADDR)) have_last <= 1'b1;
            else                           mem_addr  <= mem_addr + AW'(1);
          end
          if (wrap) begin
            if (bitn == 3'd7) begin
              if (final_q) begin
                st       <= S_IDLE;
                cfg_clk  <= 1'b1;
                cfg_dout <= 1'b1;
              end else begin
                shreg    <= nbuf;
                cfg_dout <= nbuf[0];
                bitn     <= '0;
                final_q  <= have_last;
                cfg_clk  <= 1'b0;
              end
            end else begin
              bitn     <= bitn + 3'd1;
              cfg_dout <= shreg[bitn + 3'd1];
              cfg_clk  <= 1'b0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module cfgbyte_master_chk #(
  parameter int AW       = 8,
  parameter int MAX_ADDR = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          chain_done,
  input logic          cclk,
  input logic          dout,
  input logic [AW-1:0] addr
);
  a_r1_idle_lines_high: assert property (@(posedge clk) disable iff (rst)
    !run |-> (cclk && dout));

  a_r4_dout_on_fall: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && $changed(dout)) |-> $fell(cclk));

  a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
    $changed(addr) |-> (addr == '0 || addr == $past(addr) + AW'(1)));

  a_r7_addr_bound: assert property (@(posedge clk) disable iff (rst)
    addr <= AW'(MAX_ADDR));

  a_r8_done_halts: assert property (@(posedge clk) disable iff (rst)
    (run && chain_done) |=> (!run && cclk && dout && $stable(addr)));
endmodule

bind cfgbyte_master cfgbyte_master_chk #(.AW(AW), .MAX_ADDR(MAX_ADDR)) chk_i (
  .clk(clk), .rst(rst), .run(run_w), .chain_done(chain_done),
  .cclk(cfg_clk), .dout(cfg_dout), .addr(mem_addr)
);

// File: tb/cfgbyte_master_tb.sv
module cfgbyte_master_tb_top;
  localparam int DIV = 4;
  localparam int AW  = 8;
  localparam int MAX = 5;
  localparam int NB  = MAX + 1;
  localparam int LO  = DIV / 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, chain_done = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_data;
  logic cfg_clk, cfg_dout;
  int   seed = 0;
  int   n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] memf(input int a, input int s);
    if (s == 5) return (a % 2 == 0) ? 8'hFF : 8'h00;
    if (s == 6) return 8'h01 << (a % 8);
    return 8'((a * 37 + s * 91 + 5) ^ (s * 13));
  endfunction

  assign mem_data = memf(int'(mem_addr), seed);

  cfgbyte_master #(.DIV(DIV), .AW(AW), .MAX_ADDR(MAX)) dut_i (
    .clk(clk), .rst(rst), .start(start), .chain_done(chain_done),
    .mem_addr(mem_addr), .mem_data(mem_data),
    .cfg_clk(cfg_clk), .cfg_dout(cfg_dout));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    summary();
  end

  task automatic run_full(input int s, input bit mid_start);
    logic pc, pd;
    logic [AW-1:0] pa;
    logic [7:0] acc, e0;
    int lowc, since, nrise, nbits, bytei, addr_int;
    bit first;
    seed = s;
    e0 = memf(0, s);
    acc = '0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(mem_addr == 0 && cfg_clk, "R2 address zero during wait", int'(mem_addr), 0);
    @(negedge clk);
    chk(cfg_clk == 1'b0, "R2 first clock fall", int'(cfg_clk), 0);
    chk(cfg_dout == e0[0], "R2 first bit", int'(cfg_dout), int'(e0[0]));
    chk(mem_addr == 1, "R2 address after first load", int'(mem_addr), 1);
    pc = cfg_clk; pd = cfg_dout; pa = mem_addr;
    lowc = 1; since = 0; nrise = 0; nbits = 0; bytei = 0; addr_int = 0; first = 1;
    for (int k = 1; k <= NB * 8 * DIV + 20; k++) begin
      start = mid_start && (k == 100);
      @(negedge clk);
      addr_int++; since++;
      if (!pc && cfg_clk) begin
        if (nrise > 0) chk(since == DIV, "R3 rise spacing", since, DIV);
        chk(lowc == LO, "R3 low phase", lowc, LO);
        since = 0; lowc = 0; nrise++;
        if (nbits < NB * 8) begin
          acc[nbits % 8] = cfg_dout;
          nbits++;
          if (nbits % 8 == 0) begin
            chk(acc == memf(bytei, s), "R5 byte lsb first", int'(acc), int'(memf(bytei, s)));
            bytei++;
          end
        end
      end
      if (!cfg_clk) lowc++;
      if (cfg_dout != pd && nbits < NB * 8)
        chk(pc && !cfg_clk, "R4 data change off falling edge", int'(cfg_clk), 0);
      if (mem_addr != pa) begin
        chk(mem_addr == pa + 1'b1, "R6 address step", int'(mem_addr), int'(pa) + 1);
        chk(addr_int == (first ? 8 * DIV - 1 : 8 * DIV), "R6 address interval",
            addr_int, first ? 8 * DIV - 1 : 8 * DIV);
        first = 0; addr_int = 0;
      end
      pc = cfg_clk; pd = cfg_dout; pa = mem_addr;
    end
    start = 1'b0;
    chk(nbits == NB * 8, "R7 bit total", nbits, NB * 8);
    chk(nrise == NB * 8, "R7 no extra clock pulses", nrise, NB * 8);
    chk(cfg_clk && cfg_dout, "R7 lines high when finished", int'({cfg_clk, cfg_dout}), 3);
    chk(mem_addr == MAX, "R7 address holds at max", int'(mem_addr), MAX);
  endtask

  initial begin
    logic [AW-1:0] fa;
    bit stayed;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_clk && cfg_dout, "R1 reset lines high", int'({cfg_clk, cfg_dout}), 3);
    chk(mem_addr == 0, "R1 reset address", int'(mem_addr), 0);

    for (int s = 0; s <= 6; s++) run_full(s, s % 2 == 1);

    // R8: chain_done mid-stream
    seed = 2;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (3 * 8 * DIV) @(negedge clk);
    chain_done = 1'b1;
    @(negedge clk) chain_done = 1'b0;
    chk(cfg_clk && cfg_dout, "R8 halt lines high", int'({cfg_clk, cfg_dout}), 3);
    fa = mem_addr;
    stayed = 1;
    repeat (30) begin
      @(negedge clk);
      if (!cfg_clk) stayed = 0;
    end
    chk(stayed, "R8 no clock after halt", 0, 1);
    chk(mem_addr == fa, "R8 address frozen", int'(mem_addr), int'(fa));
    run_full(3, 1'b0);

    // R1: reset in mid-stream
    seed = 1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(cfg_clk && cfg_dout, "R1 mid-stream reset lines", int'({cfg_clk, cfg_dout}), 3);
    chk(mem_addr == 0, "R1 mid-stream reset address", int'(mem_addr), 0);
    repeat (20) @(negedge clk);
    chk(cfg_clk && mem_addr == 0, "R1 stays idle after reset", int'(mem_addr), 0);
    run_full(4, 1'b0);

    summary();
  end
endmodule